// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

This block holds a bank of compare registers and watches a shared timebase count that is produced elsewhere. When the timebase advances to a value equal to one channel's compare register, that channel sets its interrupt flag and flips an output latch. The latch drives an output pin. The timebase counter itself and the arbitration of the interrupt requests are handled outside this block.

Neighbouring channels can be joined into a pair. In a pair, a match on either register flips one shared latch, and that latch appears on the even-numbered pin. With one count source, this gives a pulse whose leading and trailing edges are both programmable. Software can load every latch with a chosen starting level before compare operation begins, and each channel can be enabled on its own.

Writes use one register port. For the default six channels, the addresses are as follows:
- Addresses 0 to 5 hold the compare values.
- Address 6 is control. Bits [5:0] enable the channels and bits [8:6] select pair mode for pairs (0,1), (2,3) and (4,5).
- Address 7 holds the interrupt enables in bits [5:0].
- Address 8 loads the initial levels from bits [5:0].
- Address 9 clears flags. Each 1 in bits [5:0] clears the matching flag.

Top module: `cmp_bank`

## Requirements
- R1: After reset, every pin, flag and interrupt output is 0, and all channels are disabled and unpaired.
- R2: Suppose channel i is enabled through bit i of address 6 and `tb_adv` is high on a clock edge where `tb_count` equals compare register i (address i). Then the latch of channel i inverts, and the new level is visible after that edge.
- R3: No latch or flag changes on an edge where `tb_adv` is low, even if the count equals a compare register. A disabled channel never matches.
- R4: A match sets flag i after the same edge. `irq_o[i]` is high exactly when flag i is set and bit i of address 7 is 1.
- R5: Writing address 8+1 (address 9) clears each flag whose data bit is 1. A match on the same edge wins and leaves that flag set.
- R6: When bit 6+p of address 6 is set, pair p is in pair mode. A match on channel 2p or on channel 2p+1 inverts pin 2p, and pin 2p+1 holds its level.
- R7: If both channels of a joined pair match on the same edge, pin 2p keeps its level and both flags are set.
- R8: A write to address 8 loads every latch from data bits [5:0] on that edge. This load overrides any inversion due on the same edge.
- R9: A channel's pin and flag do not depend on the matches, compare values or enables of other channels, except through pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_count | input | 16 | Shared timebase count |
| tb_adv | input | 1 | High on a cycle where the timebase count is new |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pin_o | output | 6 | Output latch levels |
| flag_o | output | 6 | Match flags |
| irq_o | output | 6 | Flags gated by interrupt enables |

## Verification
The assertions assume that `tb_adv` is the only sign that the timebase has advanced, and that `wr_addr` values above 9 are never written. The stimulus respects both assumptions by sweeping a monotone count with `tb_adv` raised once per value and a held cycle between values, and by writing only the ten defined addresses. Every pairing mask is swept twice: once with distinct compare values and once with both registers of each pair equal. This drives the both-match case that the pair assertions cover.

// File: rtl/cmp_bank_pkg.sv
package cmp_bank_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_CMP,
      OP_CTRL,
      OP_IE,
      OP_INIT,
      OP_CLR
   } wr_op_e;

   // Map a write address onto its register class for a bank of nch channels.
   function automatic wr_op_e decode_op(input int unsigned addr, input int unsigned nch);
      if (addr < nch)           return OP_CMP;
      else if (addr == nch)     return OP_CTRL;
      else if (addr == nch + 1) return OP_IE;
      else if (addr == nch + 2) return OP_INIT;
      else if (addr == nch + 3) return OP_CLR;
      else                      return OP_NONE;
   endfunction

endpackage

// File: rtl/cmp_bank_regs.sv
module cmp_bank_regs
   import cmp_bank_pkg::*;
#(
   parameter int NCH = 6,
   parameter int TW  = 16,
   parameter int AW  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [TW-1:0]          wr_data,
   input  logic [NCH-1:0]         hit,
   output logic [NCH-1:0][TW-1:0] cmp_val,
   output logic [NCH-1:0]         ch_en,
   output logic [NCH/2-1:0]       pair_md,
   output logic [NCH-1:0]         int_en,
   output logic [NCH-1:0]         flag,
   output logic                   ld_stb,
   output logic [NCH-1:0]         ld_val
);

   localparam int NPAIR = NCH / 2;

   wr_op_e         op;
   logic [NCH-1:0] clr_v;

   assign op     = wr_en ? decode_op(int'(wr_addr), NCH) : OP_NONE;
   assign ld_stb = (op == OP_INIT);
   assign ld_val = wr_data[NCH-1:0];
   assign clr_v  = (op == OP_CLR) ? wr_data[NCH-1:0] : '0;

   for (genvar i = 0; i < NCH; i++) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_val[i] <= '0;
         else if (op == OP_CMP && int'(wr_addr) == i)
            cmp_val[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_en   <= '0;
         pair_md <= '0;
         int_en  <= '0;
      end else begin
         if (op == OP_CTRL) begin
            ch_en   <= wr_data[NCH-1:0];
            pair_md <= wr_data[NCH +: NPAIR];
         end
         if (op == OP_IE)
            int_en <= wr_data[NCH-1:0];
      end
   end

   // A new match outranks a clear on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= '0;
      else
         flag <= (flag & ~clr_v) | hit;
   end

   a_r4_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((flag & $past(hit)) == $past(hit)));

   a_r5_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLR) |=> ((flag & $past(wr_data[NCH-1:0] & ~hit)) == '0));

endmodule

// File: rtl/cmp_bank_match.sv
module cmp_bank_match #(
   parameter int NCH = 6,
   parameter int TW  = 16
) (
   input  logic                   adv,
   input  logic [TW-1:0]          count,
   input  logic [NCH-1:0][TW-1:0] cmp_val,
   input  logic [NCH-1:0]         ch_en,
   output logic [NCH-1:0]         hit
);

   for (genvar i = 0; i < NCH; i++) begin : g_eq
      assign hit[i] = adv && ch_en[i] && (count == cmp_val[i]);
   end

endmodule

// File: rtl/cmp_bank_pair.sv
module cmp_bank_pair (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] hit,
   input  logic       joined,
   input  logic       adv,
   input  logic       ld_stb,
   input  logic [1:0] ld_val,
   output logic [1:0] lvl
);

   logic [1:0] nxt;

   always_comb begin
      if (ld_stb)
         nxt = ld_val;
      else if (joined)
         nxt = {lvl[1], lvl[0] ^ hit[0] ^ hit[1]};
      else
         nxt = lvl ^ hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl <= '0;
      else
         lvl <= nxt;
   end

   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld_stb) |=> $stable(lvl));

   a_r6_odd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (joined && !ld_stb) |=> $stable(lvl[1]));

   a_r7_double_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (joined && !ld_stb && (&hit)) |=> $stable(lvl[0]));

   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |=> (lvl == $past(ld_val)));

endmodule

// File: rtl/cmp_bank.sv
module cmp_bank
   import cmp_bank_pkg::*;
#(
   parameter int NCH = 6,
   parameter int TW  = 16,
   parameter int AW  = $clog2(NCH + 4)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [TW-1:0]  tb_count,
   input  logic           tb_adv,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [TW-1:0]  wr_data,
   output logic [NCH-1:0] pin_o,
   output logic [NCH-1:0] flag_o,
   output logic [NCH-1:0] irq_o
);

   localparam int NPAIR = NCH / 2;

   if (NCH < 2 || (NCH % 2) != 0) begin : g_bad_nch
      $error("cmp_bank: NCH must be even and at least 2");
   end
   if (NCH + NPAIR > TW) begin : g_bad_tw
      $error("cmp_bank: TW too narrow for control fields");
   end
   if ((1 << AW) < NCH + 4) begin : g_bad_aw
      $error("cmp_bank: AW too narrow for register map");
   end

   logic [NCH-1:0][TW-1:0] cmp_val;
   logic [NCH-1:0]         ch_en;
   logic [NPAIR-1:0]       pair_md;
   logic [NCH-1:0]         int_en;
   logic [NCH-1:0]         hit;
   logic                   ld_stb;
   logic [NCH-1:0]         ld_val;

   cmp_bank_regs #(.NCH(NCH), .TW(TW), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .hit     (hit),
      .cmp_val (cmp_val),
      .ch_en   (ch_en),
      .pair_md (pair_md),
      .int_en  (int_en),
      .flag    (flag_o),
      .ld_stb  (ld_stb),
      .ld_val  (ld_val)
   );

   cmp_bank_match #(.NCH(NCH), .TW(TW)) u_match (
      .adv     (tb_adv),
      .count   (tb_count),
      .cmp_val (cmp_val),
      .ch_en   (ch_en),
      .hit     (hit)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      cmp_bank_pair u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (hit[2*p +: 2]),
         .joined (pair_md[p]),
         .adv    (tb_adv),
         .ld_stb (ld_stb),
         .ld_val (ld_val[2*p +: 2]),
         .lvl    (pin_o[2*p +: 2])
      );
   end

   assign irq_o = flag_o & int_en;

   a_r3_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !tb_adv |=> ((flag_o & ~$past(flag_o)) == '0));

endmodule

// File: tb/cmp_bank_test.sv
module cmp_bank_test;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] tb_count = 0;
   logic        tb_adv = 0;
   logic        wr_en = 0;
   logic [3:0]  wr_addr = 0;
   logic [15:0] wr_data = 0;
   logic [5:0]  pin_o, flag_o, irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [15:0] m_cmp [6];
   logic [5:0]  m_en = 0, m_ie = 0, m_flag = 0, m_lat = 0;
   logic [2:0]  m_pair = 0;

   always #5ns clk = ~clk;

   cmp_bank uut (
      .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_adv(tb_adv),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // One clock: drive at negedge, update model, sample at the next negedge.
   task automatic cyc(input logic [15:0] cnt, input logic adv, input logic we,
                      input logic [3:0] a, input logic [15:0] d, input string tag);
      logic [5:0] hitv, clr;
      tb_count = cnt; tb_adv = adv; wr_en = we; wr_addr = a; wr_data = d;
      for (int i = 0; i < 6; i++) hitv[i] = adv && m_en[i] && (cnt == m_cmp[i]);
      if (we && a == 4'd8) m_lat = d[5:0];
      else for (int p = 0; p < 3; p++) begin
         if (m_pair[p]) m_lat[2*p] = m_lat[2*p] ^ hitv[2*p] ^ hitv[2*p+1];
         else begin
            m_lat[2*p]   = m_lat[2*p]   ^ hitv[2*p];
            m_lat[2*p+1] = m_lat[2*p+1] ^ hitv[2*p+1];
         end
      end
      clr = (we && a == 4'd9) ? d[5:0] : 6'd0;
      m_flag = (m_flag & ~clr) | hitv;
      if (we) begin
         if (a < 4'd6) m_cmp[a] = d;
         else if (a == 4'd6) begin m_en = d[5:0]; m_pair = d[8:6]; end
         else if (a == 4'd7) m_ie = d[5:0];
      end
      @(posedge clk); @(negedge clk);
      wr_en = 0; tb_adv = 0;
      chk(tag, "pin", pin_o, m_lat);
      chk((tag == "R5") ? "R5" : "R4", "flag", flag_o, m_flag);
      chk("R4", "irq", irq_o, m_flag & m_ie);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
      cyc(16'hFFFF, 1'b0, 1'b1, a, d, tag);
   endtask

   initial begin
      #2ms;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int i = 0; i < 6; i++) m_cmp[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "pin", pin_o, 6'd0);
      chk("R1", "flag", flag_o, 6'd0);
      chk("R1", "irq", irq_o, 6'd0);
      rst_n = 1;
      @(negedge clk);
      // R3: equal count but nothing enabled
      cyc(16'd0, 1'b1, 1'b0, 4'd0, 16'd0, "R3");

      for (int dup = 0; dup < 2; dup++) begin
         for (int pm = 0; pm < 8; pm++) begin
            string tg;
            tg = dup ? "R7" : (pm == 0 ? "R2 R9" : "R6");
            wr(4'd8, 16'd0, "R8");
            wr(4'd9, 16'h003F, "R5");
            for (int i = 0; i < 6; i++)
               wr(4'(i), 16'(dup ? (i/2)*5 + 2 : i*5 + 2), tg);
            wr(4'd6, 16'((pm << 6) | 6'h3F), tg);
            wr(4'd7, 16'(6'h15 ^ (pm * 9)), "R4");
            for (int c = 0; c < 32; c++) begin
               cyc(16'(c), 1'b1, 1'b0, 4'd0, 16'd0, tg);
               cyc(16'(c), 1'b0, 1'b0, 4'd0, 16'd0, "R3");
            end
         end
      end

      // R3: disabled channels ignored, R9: enabled ones unaffected
      wr(4'd6, 16'h0009, "R3");
      for (int i = 0; i < 6; i++) wr(4'(i), 16'(40 + i), "R3");
      for (int c = 38; c < 48; c++) cyc(16'(c), 1'b1, 1'b0, 4'd0, 16'd0, "R3");

      // R8: load overrides a due toggle on the same edge
      wr(4'd6, 16'h003F, "R8");
      wr(4'd0, 16'd100, "R8");
      cyc(16'd100, 1'b1, 1'b1, 4'd8, 16'h002A, "R8");
      cyc(16'd100, 1'b1, 1'b1, 4'd8, 16'h0015, "R8");

      // R5: clear vs match on the same edge, match wins
      wr(4'd1, 16'd200, "R5");
      cyc(16'd200, 1'b1, 1'b1, 4'd9, 16'h003F, "R5");
      cyc(16'd201, 1'b1, 1'b1, 4'd9, 16'h003F, "R5");

      summary();
   end

endmodule